// File: doc/BRIEF.md
# Line-at-a-time convolution sequencer for a fused stereo CNN datapath

This controller drives one output line of one convolutional layer through a multiply-accumulate array that handles N input channels and N output channels per cycle. A single start pulse hands it a command. The command holds the layer shape in channel groups, kernel columns, kernel rows and output pixels. It also holds a merge mode, a destination code, base addresses and strides for the feature lines, and the index of the line slot that currently holds the top row of the rolling input window. After the command is taken, the sequencer issues one datapath step per cycle. Each step carries the feature read address, the memory to read from, the weight address, the bias index, the accumulator operand select, the partial-sum address, and either a partial-sum write-back or a final write with its destination.

The loop nest is fixed, from outer to inner: output-channel group, input-channel group, kernel column, kernel row, output pixel. Because the output pixel runs innermost, one weight tile stays in place for a full line sweep. Because the output group runs outermost, only one line of partial sums is live at a time. Input rows sit in a ring of line slots whose count equals the kernel height.

Four merge modes change how the two stereo paths are joined:
- plain convolution;
- concatenation, where the left-path channel groups are read from the left-path memory after the right-path groups of the same output group;
- element-wise addition, where the left-path feature replaces the bias;
- element-wise multiplication, where the left-path feature is fetched at the final pass for the product stage.

An outer scheduler chooses which line and layer to run next. This block does not make that choice.

Top module: `dfl_line_seq`

## Requirements
- R1: While reset is held and while idle, `busy`, `step_valid`, `done`, `out_wr_en` and `psum_wr_en` are all 0.
- R2: A start accepted in idle makes `step_valid` high from the next cycle for exactly KG×CT×FX×FY×OX consecutive cycles. Here CT is the right-path group count, plus the left-path group count in concatenation mode (mode code 1) only. The steps run in the order k-group, channel group, kernel column, kernel row, output pixel, with the output pixel innermost.
- R3: The feature read address equals base + slot×row_stride + group×grp_stride + ox + fx, taken modulo 2^ADDR_W. The slot is (ptr + fy) mod FY.
- R4: In concatenation mode, within each k-group, the right-path groups are read from the main memory (`feat_from_left`=0, base `cmd_in_base`). The left-path groups then follow from the left memory (`feat_from_left`=1, base `cmd_left_base`, group index restarting at 0). In every other mode `feat_from_left` is 0.
- R5: The weight address starts at `cmd_wgt_base`. It advances by one after each full output-pixel sweep and holds steady within a sweep.
- R6: On the first pass over a pixel (channel group, kernel column and kernel row all 0), `acc_src` is 0 (bias), or 1 (left-path feature) in addition mode (code 2). On every later pass it is 2 (partial sum).
- R7: On the final pass (last channel group, last column, last row), `out_wr_en`=1 and `out_addr` = out_base + k×out_stride + ox. On every other step `psum_wr_en`=1. `psum_addr` is ox on every step.
- R8: `out_dest` follows the destination code: 0 is main memory, 1 is left-path memory, 2 is external. Code 3, and code 1 in concatenation mode, both go to main memory.
- R9: `side_rd_en` is high on first passes in addition mode and on final passes in multiplication mode (code 3), with `side_addr` = left_base + k×out_stride + ox. `mul_merge` is high on final passes in multiplication mode only.
- R10: `done` pulses high for one cycle in the cycle after the last step, and `busy` is then low. A start pulse while busy is ignored and the running command is kept.
- R11: `bias_addr` equals the current output-channel group index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Take the command (honoured only when idle) |
| cmd_mode | input | 2 | Merge mode: 0 conv, 1 concat, 2 add, 3 multiply |
| cmd_dest | input | 2 | Destination code of finished outputs |
| cmd_kgrp | input | DIM_W | Output-channel group count (≥1) |
| cmd_cgrp | input | DIM_W | Right-path / plain input-channel group count (≥1) |
| cmd_cgrp_left | input | DIM_W | Left-path group count, used in concat mode |
| cmd_fx | input | DIM_W | Kernel columns (≥1) |
| cmd_fy | input | DIM_W | Kernel rows and ring slot count (≥1) |
| cmd_ox | input | DIM_W | Output pixels in the line (≥1) |
| cmd_ptr | input | DIM_W | Ring slot holding the top row (< cmd_fy) |
| cmd_in_base | input | ADDR_W | Base of input lines in main memory |
| cmd_left_base | input | ADDR_W | Base in left-path memory |
| cmd_out_base | input | ADDR_W | Base of the output line |
| cmd_wgt_base | input | ADDR_W | First weight tile address |
| cmd_row_stride | input | ADDR_W | Words between ring slots |
| cmd_grp_stride | input | ADDR_W | Words between channel groups in a slot |
| cmd_out_stride | input | ADDR_W | Words between output groups |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| step_valid | output | 1 | A datapath step is issued this cycle |
| feat_addr | output | ADDR_W | Feature read address |
| feat_from_left | output | 1 | Feature comes from the left-path memory |
| wgt_addr | output | ADDR_W | Weight tile address |
| bias_addr | output | ADDR_W | Bias index |
| acc_src | output | 2 | Accumulator operand: 0 bias, 1 left feature, 2 partial sum, 3 none |
| psum_addr | output | ADDR_W | Partial-sum slot |
| psum_wr_en | output | 1 | Write back a partial sum |
| side_rd_en | output | 1 | Read left-path feature for a merge |
| side_addr | output | ADDR_W | Left-path merge feature address |
| mul_merge | output | 1 | Route result through the product stage |
| out_wr_en | output | 1 | Final output write |
| out_addr | output | ADDR_W | Final output address |
| out_dest | output | 2 | Resolved destination: 0 main, 1 left, 2 external |

## Verification
The bench targets the following corner cases:
- **Single-step command.** Every count is 1, so the first and final passes coincide. A design that split them would emit a partial-sum write or a bias-less final write.
- **Ring-pointer wrap.** A non-zero pointer makes the slot index wrap. A design that forgot the modulo would read past the ring.
- **Concatenation hand-off.** The bench watches the hand-off from right-path to left-path groups. An off-by-one there would read the wrong memory or skip group 0 of the left path.
- **Concatenation with the left-path destination.** A missing redirect would overwrite the left-path lines still in use.
- **Start pulse mid-run with a scrambled command.** A design that re-latched the command would change the address sequence in mid-run.

// File: rtl/dfl_seq_pkg.sv
package dfl_seq_pkg;

    typedef enum logic [1:0] {
        MODE_CONV = 2'd0,
        MODE_CAT  = 2'd1,
        MODE_ADD  = 2'd2,
        MODE_MUL  = 2'd3
    } merge_e;

    typedef enum logic [1:0] {
        DST_MAIN = 2'd0,
        DST_LEFT = 2'd1,
        DST_EXT  = 2'd2,
        DST_RSVD = 2'd3
    } dest_e;

    typedef enum logic [1:0] {
        ACC_BIAS = 2'd0,
        ACC_SIDE = 2'd1,
        ACC_PSUM = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // loop levels, innermost first
    localparam int LOOP_LEVELS = 5;
    localparam int LVL_OX = 0;
    localparam int LVL_FY = 1;
    localparam int LVL_FX = 2;
    localparam int LVL_CH = 3;
    localparam int LVL_KG = 4;

endpackage

// File: rtl/dfl_loop_nest.sv
module dfl_loop_nest #(
    parameter int LEVELS = 5,
    parameter int W      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         advance,
    input  logic [LEVELS-1:0][W-1:0]     limit,
    output logic [LEVELS-1:0][W-1:0]     idx,
    output logic [LEVELS-1:0]            at_last,
    output logic                         wrap
);

    logic [LEVELS-1:0][W-1:0] idx_d, idx_q;
    logic [LEVELS:0]          carry;

    assign carry[0] = advance;

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
            assign at_last[g]  = (idx_q[g] == (limit[g] - W'(1)));
            assign carry[g+1]  = carry[g] & at_last[g];

            // R2: every level index stays inside its trip count while stepping
            assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
                advance |-> (idx_q[g] < limit[g]))
                else $error("loop index out of range at level %0d", g);
        end
    endgenerate

    assign wrap = carry[LEVELS];

    always_comb begin
        idx_d = idx_q;
        for (int i = 0; i < LEVELS; i++) begin
            if (clear) begin
                idx_d[i] = '0;
            end else if (carry[i]) begin
                idx_d[i] = at_last[i] ? '0 : idx_q[i] + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx = idx_q;

endmodule

// File: rtl/dfl_addr_gen.sv
module dfl_addr_gen
    import dfl_seq_pkg::*;
#(
    parameter int W      = 8,
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        mode,
    input  logic [W-1:0]      rows,
    input  logic [W-1:0]      ptr,
    input  logic [W-1:0]      cgrp_right,
    input  logic [W-1:0]      kg,
    input  logic [W-1:0]      ch,
    input  logic [W-1:0]      fx,
    input  logic [W-1:0]      fy,
    input  logic [W-1:0]      ox,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [ADDR_W-1:0] left_base,
    input  logic [ADDR_W-1:0] out_base,
    input  logic [ADDR_W-1:0] row_stride,
    input  logic [ADDR_W-1:0] grp_stride,
    input  logic [ADDR_W-1:0] out_stride,
    output logic [ADDR_W-1:0] feat_addr,
    output logic              feat_from_left,
    output logic [ADDR_W-1:0] side_addr,
    output logic [ADDR_W-1:0] out_addr
);

    function automatic logic [ADDR_W-1:0] widen(input logic [W-1:0] v);
        return {{(ADDR_W-W){1'b0}}, v};
    endfunction

    logic [ADDR_W-1:0] slot_sum;
    logic [ADDR_W-1:0] slot;
    logic [W-1:0]      grp_idx;
    logic [ADDR_W-1:0] line_base;
    logic [ADDR_W-1:0] pix_off;

    always_comb begin
        // ring slot of kernel row fy, counted from the top-row pointer
        slot_sum = widen(ptr) + widen(fy);
        slot     = (slot_sum >= widen(rows)) ? (slot_sum - widen(rows)) : slot_sum;

        // concatenation: groups past the right-path count come from the left memory
        feat_from_left = (mode == MODE_CAT) && (ch >= cgrp_right);
        grp_idx        = feat_from_left ? (ch - cgrp_right) : ch;
        line_base      = feat_from_left ? left_base : in_base;

        pix_off   = widen(ox) + widen(fx);
        feat_addr = line_base + slot * row_stride + widen(grp_idx) * grp_stride + pix_off;

        side_addr = left_base + widen(kg) * out_stride + widen(ox);
        out_addr  = out_base  + widen(kg) * out_stride + widen(ox);
    end

endmodule

// File: rtl/dfl_line_seq.sv
module dfl_line_seq
    import dfl_seq_pkg::*;
#(
    parameter int DIM_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cmd_mode,
    input  logic [1:0]        cmd_dest,
    input  logic [DIM_W-1:0]  cmd_kgrp,
    input  logic [DIM_W-1:0]  cmd_cgrp,
    input  logic [DIM_W-1:0]  cmd_cgrp_left,
    input  logic [DIM_W-1:0]  cmd_fx,
    input  logic [DIM_W-1:0]  cmd_fy,
    input  logic [DIM_W-1:0]  cmd_ox,
    input  logic [DIM_W-1:0]  cmd_ptr,
    input  logic [ADDR_W-1:0] cmd_in_base,
    input  logic [ADDR_W-1:0] cmd_left_base,
    input  logic [ADDR_W-1:0] cmd_out_base,
    input  logic [ADDR_W-1:0] cmd_wgt_base,
    input  logic [ADDR_W-1:0] cmd_row_stride,
    input  logic [ADDR_W-1:0] cmd_grp_stride,
    input  logic [ADDR_W-1:0] cmd_out_stride,
    output logic              busy,
    output logic              done,
    output logic              step_valid,
    output logic [ADDR_W-1:0] feat_addr,
    output logic              feat_from_left,
    output logic [ADDR_W-1:0] wgt_addr,
    output logic [ADDR_W-1:0] bias_addr,
    output logic [1:0]        acc_src,
    output logic [ADDR_W-1:0] psum_addr,
    output logic              psum_wr_en,
    output logic              side_rd_en,
    output logic [ADDR_W-1:0] side_addr,
    output logic              mul_merge,
    output logic              out_wr_en,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_dest
);

    localparam int LEVELS = LOOP_LEVELS;

    typedef struct packed {
        logic [1:0]        mode;
        logic [1:0]        dest;
        logic [DIM_W-1:0]  kgrp;
        logic [DIM_W-1:0]  ctot;
        logic [DIM_W-1:0]  cgrp;
        logic [DIM_W-1:0]  fx;
        logic [DIM_W-1:0]  fy;
        logic [DIM_W-1:0]  ox;
        logic [DIM_W-1:0]  ptr;
        logic [ADDR_W-1:0] in_base;
        logic [ADDR_W-1:0] left_base;
        logic [ADDR_W-1:0] out_base;
        logic [ADDR_W-1:0] row_stride;
        logic [ADDR_W-1:0] grp_stride;
        logic [ADDR_W-1:0] out_stride;
    } cmd_t;

    typedef struct packed {
        phase_e            phase;
        cmd_t              cmd;
        logic [ADDR_W-1:0] wgt;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    logic                         ctr_clear;
    logic                         ctr_adv;
    logic [LEVELS-1:0][DIM_W-1:0] limit;
    logic [LEVELS-1:0][DIM_W-1:0] idx;
    logic [LEVELS-1:0]            at_last;
    logic                         nest_wrap;

    function automatic logic [ADDR_W-1:0] widen(input logic [DIM_W-1:0] v);
        return {{(ADDR_W-DIM_W){1'b0}}, v};
    endfunction

    // ---------------------------------------------------------------
    // next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        ctr_clear = 1'b0;
        ctr_adv   = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase          = PH_RUN;
                    st_d.cmd.mode       = cmd_mode;
                    st_d.cmd.dest       = cmd_dest;
                    st_d.cmd.kgrp       = cmd_kgrp;
                    st_d.cmd.cgrp       = cmd_cgrp;
                    st_d.cmd.ctot       = cmd_cgrp +
                                          ((cmd_mode == MODE_CAT) ? cmd_cgrp_left : '0);
                    st_d.cmd.fx         = cmd_fx;
                    st_d.cmd.fy         = cmd_fy;
                    st_d.cmd.ox         = cmd_ox;
                    st_d.cmd.ptr        = cmd_ptr;
                    st_d.cmd.in_base    = cmd_in_base;
                    st_d.cmd.left_base  = cmd_left_base;
                    st_d.cmd.out_base   = cmd_out_base;
                    st_d.cmd.row_stride = cmd_row_stride;
                    st_d.cmd.grp_stride = cmd_grp_stride;
                    st_d.cmd.out_stride = cmd_out_stride;
                    st_d.wgt            = cmd_wgt_base;
                    ctr_clear           = 1'b1;
                end
            end
            PH_RUN: begin
                ctr_adv = 1'b1;
                if (at_last[LVL_OX]) begin
                    st_d.wgt = st_q.wgt + ADDR_W'(1);
                end
                if (nest_wrap) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------------------------------------------------------
    // loop nest and address generation
    // ---------------------------------------------------------------
    assign limit[LVL_KG] = st_q.cmd.kgrp;
    assign limit[LVL_CH] = st_q.cmd.ctot;
    assign limit[LVL_FX] = st_q.cmd.fx;
    assign limit[LVL_FY] = st_q.cmd.fy;
    assign limit[LVL_OX] = st_q.cmd.ox;

    dfl_loop_nest #(
        .LEVELS (LEVELS),
        .W      (DIM_W)
    ) u_nest (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctr_clear),
        .advance (ctr_adv),
        .limit   (limit),
        .idx     (idx),
        .at_last (at_last),
        .wrap    (nest_wrap)
    );

    logic [ADDR_W-1:0] ag_feat, ag_side, ag_out;
    logic              ag_left;

    dfl_addr_gen #(
        .W      (DIM_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .mode           (st_q.cmd.mode),
        .rows           (st_q.cmd.fy),
        .ptr            (st_q.cmd.ptr),
        .cgrp_right     (st_q.cmd.cgrp),
        .kg             (idx[LVL_KG]),
        .ch             (idx[LVL_CH]),
        .fx             (idx[LVL_FX]),
        .fy             (idx[LVL_FY]),
        .ox             (idx[LVL_OX]),
        .in_base        (st_q.cmd.in_base),
        .left_base      (st_q.cmd.left_base),
        .out_base       (st_q.cmd.out_base),
        .row_stride     (st_q.cmd.row_stride),
        .grp_stride     (st_q.cmd.grp_stride),
        .out_stride     (st_q.cmd.out_stride),
        .feat_addr      (ag_feat),
        .feat_from_left (ag_left),
        .side_addr      (ag_side),
        .out_addr       (ag_out)
    );

    // ---------------------------------------------------------------
    // step outputs
    // ---------------------------------------------------------------
    logic first_pass, final_pass, running;

    always_comb begin
        running    = (st_q.phase == PH_RUN);
        first_pass = (idx[LVL_CH] == '0) && (idx[LVL_FX] == '0) && (idx[LVL_FY] == '0);
        final_pass = at_last[LVL_CH] && at_last[LVL_FX] && at_last[LVL_FY];

        busy           = running;
        step_valid     = running;
        done           = st_q.done;
        feat_addr      = ag_feat;
        feat_from_left = running && ag_left;
        wgt_addr       = st_q.wgt;
        bias_addr      = widen(idx[LVL_KG]);
        psum_addr      = widen(idx[LVL_OX]);
        side_addr      = ag_side;
        out_addr       = ag_out;

        if (!running) begin
            acc_src = ACC_NONE;
        end else if (first_pass) begin
            acc_src = (st_q.cmd.mode == MODE_ADD) ? ACC_SIDE : ACC_BIAS;
        end else begin
            acc_src = ACC_PSUM;
        end

        out_wr_en  = running && final_pass;
        psum_wr_en = running && !final_pass;
        side_rd_en = running && (((st_q.cmd.mode == MODE_ADD) && first_pass) ||
                                 ((st_q.cmd.mode == MODE_MUL) && final_pass));
        mul_merge  = running && (st_q.cmd.mode == MODE_MUL) && final_pass;

        if ((st_q.cmd.dest == DST_RSVD) ||
            ((st_q.cmd.dest == DST_LEFT) && (st_q.cmd.mode == MODE_CAT))) begin
            out_dest = DST_MAIN;
        end else begin
            out_dest = st_q.cmd.dest;
        end
    end

    // ---------------------------------------------------------------
    // assertions
    // ---------------------------------------------------------------
    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one cycle");

    // R10: completion only follows a running step
    assert_done_after_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(step_valid))
        else $error("done without a preceding step");

    // R5: weight tile held stationary inside one pixel sweep
    assert_wgt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && $past(step_valid) && (idx[LVL_OX] != '0)) |->
            (wgt_addr == $past(wgt_addr)))
        else $error("weight address moved inside a sweep");

    // R3: consecutive pixels of one sweep read consecutive feature words
    assert_feat_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && $past(step_valid) && (idx[LVL_OX] != '0)) |->
            (feat_addr == $past(feat_addr) + ADDR_W'(1)))
        else $error("feature address not contiguous inside a sweep");

    // R7: each step has exactly one result sink
    assert_one_sink_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> ($countones({out_wr_en, psum_wr_en}) == 1))
        else $error("step without exactly one result sink");

    // R8: left-path memory never written while concatenating
    assert_cat_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr_en && (st_q.cmd.mode == MODE_CAT)) |-> (out_dest != DST_LEFT))
        else $error("concatenation result sent to left-path memory");

    // R1: nothing issued while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_wr_en && !psum_wr_en && !side_rd_en))
        else $error("write or read strobe while idle");

endmodule

// File: tb/tb_dfl_line_seq.sv
`timescale 1ns/1ps
module tb_dfl_line_seq;

    localparam int DIM_W  = 8;
    localparam int ADDR_W = 16;
    localparam int AMASK  = (1 << ADDR_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        cmd_mode = '0;
    logic [1:0]        cmd_dest = '0;
    logic [DIM_W-1:0]  cmd_kgrp = 8'd1, cmd_cgrp = 8'd1, cmd_cgrp_left = '0;
    logic [DIM_W-1:0]  cmd_fx = 8'd1, cmd_fy = 8'd1, cmd_ox = 8'd1, cmd_ptr = '0;
    logic [ADDR_W-1:0] cmd_in_base = '0, cmd_left_base = '0, cmd_out_base = '0;
    logic [ADDR_W-1:0] cmd_wgt_base = '0, cmd_row_stride = '0, cmd_grp_stride = '0;
    logic [ADDR_W-1:0] cmd_out_stride = '0;

    logic              busy, done, step_valid, feat_from_left;
    logic [ADDR_W-1:0] feat_addr, wgt_addr, bias_addr, psum_addr, side_addr, out_addr;
    logic [1:0]        acc_src, out_dest;
    logic              psum_wr_en, side_rd_en, mul_merge, out_wr_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dfl_line_seq #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_mode(cmd_mode), .cmd_dest(cmd_dest), .cmd_kgrp(cmd_kgrp),
        .cmd_cgrp(cmd_cgrp), .cmd_cgrp_left(cmd_cgrp_left), .cmd_fx(cmd_fx),
        .cmd_fy(cmd_fy), .cmd_ox(cmd_ox), .cmd_ptr(cmd_ptr),
        .cmd_in_base(cmd_in_base), .cmd_left_base(cmd_left_base),
        .cmd_out_base(cmd_out_base), .cmd_wgt_base(cmd_wgt_base),
        .cmd_row_stride(cmd_row_stride), .cmd_grp_stride(cmd_grp_stride),
        .cmd_out_stride(cmd_out_stride),
        .busy(busy), .done(done), .step_valid(step_valid),
        .feat_addr(feat_addr), .feat_from_left(feat_from_left),
        .wgt_addr(wgt_addr), .bias_addr(bias_addr), .acc_src(acc_src),
        .psum_addr(psum_addr), .psum_wr_en(psum_wr_en),
        .side_rd_en(side_rd_en), .side_addr(side_addr), .mul_merge(mul_merge),
        .out_wr_en(out_wr_en), .out_addr(out_addr), .out_dest(out_dest)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_dest(input int mode, input int dest);
        if (dest == 3 || (dest == 1 && mode == 1)) return 0;
        return dest;
    endfunction

    function automatic int exp_feat(input int mode, input int cg, input int c, input int x,
                                    input int y, input int o, input int ptr, input int fy,
                                    input int inb, input int lb, input int rs, input int gs);
        bit left;
        int gi;
        left = (mode == 1) && (c >= cg);
        gi   = left ? c - cg : c;
        return ((left ? lb : inb) + ((ptr + y) % fy) * rs + gi * gs + o + x) & AMASK;
    endfunction

    task automatic run_cmd(input int mode, input int dest, input int kg, input int cg,
                           input int cl, input int fx, input int fy, input int ox,
                           input int ptr, input int inb, input int lb, input int ob,
                           input int wb, input int rs, input int gs, input int os,
                           input bit poke);
        int ct, w, s;
        bit first, fin, side_exp;
        @(negedge clk);
        cmd_mode = 2'(mode);   cmd_dest = 2'(dest);
        cmd_kgrp = 8'(kg);     cmd_cgrp = 8'(cg);     cmd_cgrp_left = 8'(cl);
        cmd_fx = 8'(fx);       cmd_fy = 8'(fy);       cmd_ox = 8'(ox);
        cmd_ptr = 8'(ptr);
        cmd_in_base = 16'(inb); cmd_left_base = 16'(lb); cmd_out_base = 16'(ob);
        cmd_wgt_base = 16'(wb); cmd_row_stride = 16'(rs); cmd_grp_stride = 16'(gs);
        cmd_out_stride = 16'(os);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ct = cg + ((mode == 1) ? cl : 0);
        w  = wb;
        s  = 0;
        for (int k = 0; k < kg; k++) begin
            for (int c = 0; c < ct; c++) begin
                for (int x = 0; x < fx; x++) begin
                    for (int y = 0; y < fy; y++) begin
                        for (int o = 0; o < ox; o++) begin
                            first = (c == 0) && (x == 0) && (y == 0);
                            fin   = (c == ct - 1) && (x == fx - 1) && (y == fy - 1);
                            side_exp = ((mode == 2) && first) || ((mode == 3) && fin);
                            chk("R2 step_valid", int'(step_valid), 1);
                            chk("R3 feat_addr", int'(feat_addr),
                                exp_feat(mode, cg, c, x, y, o, ptr, fy, inb, lb, rs, gs));
                            chk("R4 feat_from_left", int'(feat_from_left),
                                int'((mode == 1) && (c >= cg)));
                            chk("R5 wgt_addr", int'(wgt_addr), w & AMASK);
                            chk("R11 bias_addr", int'(bias_addr), k);
                            chk("R6 acc_src", int'(acc_src),
                                first ? ((mode == 2) ? 1 : 0) : 2);
                            chk("R7 out_wr_en", int'(out_wr_en), int'(fin));
                            chk("R7 psum_wr_en", int'(psum_wr_en), int'(!fin));
                            chk("R7 psum_addr", int'(psum_addr), o);
                            if (fin) begin
                                chk("R7 out_addr", int'(out_addr), (ob + k * os + o) & AMASK);
                                chk("R8 out_dest", int'(out_dest), exp_dest(mode, dest));
                            end
                            chk("R9 side_rd_en", int'(side_rd_en), int'(side_exp));
                            chk("R9 mul_merge", int'(mul_merge), int'((mode == 3) && fin));
                            if (side_exp)
                                chk("R9 side_addr", int'(side_addr), (lb + k * os + o) & AMASK);
                            if (poke && s == 2) begin
                                start = 1'b1;
                                cmd_mode = 2'(mode ^ 1); cmd_kgrp = 8'd7; cmd_ox = 8'd2;
                                cmd_in_base = 16'h5555; cmd_wgt_base = 16'h0F0F;
                                cmd_ptr = 8'd0; cmd_dest = 2'd2;
                            end
                            @(negedge clk);
                            start = 1'b0;
                            s++;
                        end
                        w++;
                    end
                end
            end
        end
        chk("R10 done pulse", int'(done), 1);
        chk("R10 busy low at done", int'(busy), 0);
        chk("R2 no extra step", int'(step_valid), 0);
        @(negedge clk);
        chk("R10 done drops", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 step_valid in reset", int'(step_valid), 0);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 out_wr_en in reset", int'(out_wr_en), 0);
        chk("R1 psum_wr_en in reset", int'(psum_wr_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 busy idle", int'(busy), 0);
        chk("R1 step_valid idle", int'(step_valid), 0);

        // single step: first and final pass coincide, external destination
        run_cmd(0, 2, 1, 1, 0, 1, 1, 1, 0, 100, 0, 300, 40, 16, 4, 8, 1'b0);
        // concat with left destination redirected, ring pointer wraps
        run_cmd(1, 1, 2, 2, 2, 2, 3, 4, 2, 1000, 2000, 3000, 7, 64, 16, 5, 1'b0);
        // addition merge
        run_cmd(2, 0, 2, 2, 0, 3, 3, 5, 1, 500, 800, 900, 0, 32, 8, 6, 1'b0);
        // multiplication merge, left-path destination allowed
        run_cmd(3, 1, 2, 1, 0, 1, 2, 6, 1, 50, 60, 70, 3, 12, 6, 6, 1'b0);
        // reserved destination, start pulse while busy ignored (R10)
        run_cmd(0, 3, 2, 2, 0, 2, 2, 3, 1, 10, 20, 30, 9, 10, 5, 4, 1'b1);
        // concat, busy-start ignored
        run_cmd(1, 2, 1, 1, 1, 2, 2, 4, 1, 64, 128, 256, 1, 20, 9, 4, 1'b1);
        // address wrap at the top of the address space
        run_cmd(0, 0, 2, 1, 0, 2, 2, 4, 1, 65530, 0, 65534, 65535, 3, 2, 3, 1'b0);

        for (int r = 0; r < 25; r++) begin
            int fy_r;
            fy_r = 1 + int'($urandom % 3);
            run_cmd(int'($urandom % 4), int'($urandom % 4),
                    1 + int'($urandom % 3), 1 + int'($urandom % 3), int'($urandom % 3),
                    1 + int'($urandom % 3), fy_r, 1 + int'($urandom % 8),
                    int'($urandom % fy_r),
                    int'($urandom % 4096), int'($urandom % 4096), int'($urandom % 4096),
                    int'($urandom % 4096), 1 + int'($urandom % 64),
                    1 + int'($urandom % 16), 1 + int'($urandom % 16), (r % 5) == 0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule